// File: doc/BRIEF.md
# Multiplexed-Bus Address Latch and I/O Select Decoder

This block sits beside a processor whose low address byte shares pins with its data byte. When the address-latch-enable strobe falls, the low-order address on the shared bus is valid. The block captures that address and holds it for the rest of the bus cycle. It then decodes the held address, together with the separately routed address line 12, into two active-low chip selects for a pair of peripheral devices.

ALE is an asynchronous input. It is sampled on the system clock, and a falling edge is found by comparing two registered samples. One clock after the edge is found, the bus byte is written into the latch.

Decoding is open only while three conditions hold together: line 12 is high, latched bit 5 is high and latched bit 4 is low. Within that window, latched bits 2..0 (bit 0 least significant) choose one of eight codes, and only codes 0 and 1 reach a pin. As a result, hexadecimal address 1020 selects the first device and 1021 selects the second.

Top module: `io_addr_decode`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `latAddr` to 0 and holds both `selN` bits at 1.
- R2: After `aleIn` goes from 1 to 0 and then stays low, `latAddr` equals `adBus[5:0]` from the third rising clock edge onward. `adBus` must be held stable over those three edges.
- R3: `latAddr` changes only on an `aleIn` falling edge. Changes on `adBus` while `aleIn` is steady, and rising edges of `aleIn`, leave it unchanged.
- R4: `adBus[7:6]` is never stored and has no effect on `latAddr` or `selN`.
- R5: If `a12In` is 0, or `latAddr[5]` is 0, or `latAddr[4]` is 1, then `selN` is `2'b11`.
- R6: If the decode window is open and `latAddr[2:0]` is 3'b000, then `selN` is `2'b10` (bit 0 low). Address hex 1020 gives this result.
- R7: If the decode window is open and `latAddr[2:0]` is 3'b001, then `selN` is `2'b01` (bit 1 low). Address hex 1021 gives this result.
- R8: If the decode window is open and `latAddr[2:0]` is any value from 2 to 7, then `selN` is `2'b11`. Address hex 1022 gives this result.
- R9: `selN` follows a change of `a12In` combinationally, with no new `aleIn` edge.
- R10: At no time are both `selN` bits low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aleIn | input | 1 | Address latch enable; address is valid on its falling edge |
| adBus | input | 8 | Multiplexed low address/data byte |
| a12In | input | 1 | Address line 12, not multiplexed |
| latAddr | output | 6 | Held low-order address bits 5..0 |
| selN | output | 2 | Active-low device selects, index = decoded code |

## Verification
A corrupt latch register appears at `latAddr` in the same cycle. It reaches `selN` only when the corrupted bits are among bits 5, 4 or 2..0 and `a12In` is high. An edge detector that stays stuck, or fires twice, shows up as a capture that never happens or a capture that happens at the wrong time. The bench catches this at the fixed three-edge sample point, and also by moving `adBus` while ALE is steady or rising. A decode fault shows up at once as a wrong select. Sweeping `a12In` directly after each capture exposes a decode that does not follow line 12.

// File: rtl/io_addr_decode_pkg.sv
package io_addr_decode_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // write bus byte into the address latch this cycle
  } ctrlStb_t;
endpackage

// File: rtl/io_addr_ctrl.sv
module io_addr_ctrl
  import io_addr_decode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     aleIn,
  output ctrlStb_t stb
);
  logic aleQ;
  logic aleQQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      aleQ  <= 1'b0;
      aleQQ <= 1'b0;
    end else begin
      aleQ  <= aleIn;
      aleQQ <= aleQ;
    end
  end

  // falling edge seen between the two samples
  always_comb begin
    stb.capture = aleQQ & ~aleQ;
  end
endmodule

// File: rtl/io_addr_dp.sv
module io_addr_dp
  import io_addr_decode_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int KEEP_W    = 6,
  parameter int CODE_W    = 3,
  parameter int OUT_N     = 2,
  parameter int EN_HI_BIT = 5,
  parameter int EN_LO_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStb_t          stb,
  input  logic [BUS_W-1:0]  adBus,
  input  logic              a12In,
  output logic [KEEP_W-1:0] latAddr,
  output logic [OUT_N-1:0]  selN
);
  logic [KEEP_W-1:0] addrReg;
  logic              winOpen;
  logic [CODE_W-1:0] code;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
    end else if (stb.capture) begin
      addrReg <= adBus[KEEP_W-1:0];
    end
  end

  assign latAddr = addrReg;
  assign code    = addrReg[CODE_W-1:0];
  assign winOpen = a12In & addrReg[EN_HI_BIT] & ~addrReg[EN_LO_BIT];

  for (genvar gi = 0; gi < OUT_N; gi++) begin : g_sel
    assign selN[gi] = ~(winOpen && (code == CODE_W'(gi)));
  end
endmodule

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_addr_decode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       aleIn,
  input  logic [7:0] adBus,
  input  logic       a12In,
  output logic [5:0] latAddr,
  output logic [1:0] selN
);
  ctrlStb_t ctrlStb;

  io_addr_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .aleIn (aleIn),
    .stb   (ctrlStb)
  );

  io_addr_dp #(
    .BUS_W(8), .KEEP_W(6), .CODE_W(3), .OUT_N(2), .EN_HI_BIT(5), .EN_LO_BIT(4)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (ctrlStb),
    .adBus   (adBus),
    .a12In   (a12In),
    .latAddr (latAddr),
    .selN    (selN)
  );
endmodule

// File: rtl/io_addr_decode_chk.sv
module io_addr_decode_chk (
  input logic       clk,
  input logic       rst,
  input logic       capture,
  input logic [7:0] adBus,
  input logic       a12In,
  input logic [5:0] latAddr,
  input logic [1:0] selN
);
  logic winOpen;
  assign winOpen = a12In && latAddr[5] && !latAddr[4];

  p_reset_r1: assert property (@(posedge clk) rst |=> (latAddr == 6'd0));
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    capture |=> (latAddr == $past(adBus[5:0])));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!capture && !rst) |=> $stable(latAddr));
  p_closed_r5: assert property (@(posedge clk) disable iff (rst)
    !winOpen |-> (selN == 2'b11));
  p_code0_r6: assert property (@(posedge clk) disable iff (rst)
    (winOpen && latAddr[2:0] == 3'd0) |-> (selN == 2'b10));
  p_code1_r7: assert property (@(posedge clk) disable iff (rst)
    (winOpen && latAddr[2:0] == 3'd1) |-> (selN == 2'b01));
  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~selN));
endmodule

bind io_addr_decode io_addr_decode_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .capture (ctrlStb.capture),
  .adBus   (adBus),
  .a12In   (a12In),
  .latAddr (latAddr),
  .selN    (selN)
);

// File: tb/io_addr_decode_bench.sv
module io_addr_decode_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       aleIn;
  logic [7:0] adBus;
  logic       a12In;
  logic [5:0] latAddr;
  logic [1:0] selN;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  io_addr_decode u_io_addr_decode (
    .clk(clk), .rst(rst), .aleIn(aleIn), .adBus(adBus),
    .a12In(a12In), .latAddr(latAddr), .selN(selN)
  );

  function automatic logic [1:0] expSel(input logic a12, input logic [5:0] la);
    logic open;
    open = a12 && la[5] && !la[4];
    if (open && la[2:0] == 3'd0) return 2'b10;
    if (open && la[2:0] == 3'd1) return 2'b01;
    return 2'b11;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // one ALE cycle placing a 16-bit address, then check latch and selects
  task automatic busCycle(input logic [15:0] addr, input string tag);
    aleIn = 1'b1; adBus = addr[7:0]; a12In = addr[12];
    edges(3);
    aleIn = 1'b0;
    edges(3);
    chk({tag, " R2 latch"}, {2'b00, latAddr}, {2'b00, addr[5:0]});
    chk({tag, " R5-8 sel"}, {6'd0, selN}, {6'd0, expSel(addr[12], addr[5:0])});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] held;
    void'($urandom(32'd1020));
    rst = 1'b1; aleIn = 1'b0; adBus = 8'hFF; a12In = 1'b1;
    edges(3);
    // R1 reset state
    chk("R1 latch", {2'b00, latAddr}, 8'd0);
    chk("R1 sel", {6'd0, selN}, 8'h03);
    rst = 1'b0;
    edges(1);

    busCycle(16'h1020, "R6 1020");
    busCycle(16'h1021, "R7 1021");
    busCycle(16'h1022, "R8 1022");
    busCycle(16'h1027, "R8 1027");
    busCycle(16'h0020, "R5 a12 low");
    busCycle(16'h1030, "R5 bit4 high");
    busCycle(16'h1010, "R5 bit5 low");
    busCycle(16'h10E1, "R4 top bits");
    chk("R4 top bits ignored", {6'd0, selN}, 8'h01);

    // R9: a12 toggles without ALE
    busCycle(16'h1020, "R9 setup");
    a12In = 1'b0; #1;
    chk("R9 a12 low", {6'd0, selN}, 8'h03);
    a12In = 1'b1; #1;
    chk("R9 a12 high", {6'd0, selN}, 8'h02);

    // R3: bus moves with ALE low, then ALE rises with new bus
    held = latAddr;
    adBus = 8'h15; edges(4);
    chk("R3 bus move ale low", {2'b00, latAddr}, {2'b00, held});
    aleIn = 1'b1; adBus = 8'h3B; edges(4);
    chk("R3 ale rise", {2'b00, latAddr}, {2'b00, held});
    adBus = 8'h07; edges(4);
    chk("R3 bus move ale high", {2'b00, latAddr}, {2'b00, held});

    // random mix, addresses biased toward the decode window
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (i % 2 == 0) a = {8'h10, 2'($urandom), 3'b100, 3'($urandom % 3)};
      busCycle(a, "rand");
      chk("R10 onehot", {7'd0, (selN == 2'b00)}, 8'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule